// File: doc/BRIEF.md
# GPIO Pin Register Bank

This block keeps the configuration and data state for a row of general-purpose pins and presents it through a flat memory-mapped register port. Every pin owns two words: a control word that selects the peripheral function, the pull or keeper arrangement, the drive strength and the direction, and an I/O word that carries the value to drive and the level sampled from the pad. The register state is decoded straight onto pad-side control outputs, so software sees a pin change in the cycle after its write lands.

Writes carry a bit mask. Only the bits set in the mask are written, so one field can be changed without a read-modify-write sequence and without touching the other fields of the word. The pad input passes through a two-stage synchronizer before it is shown in the I/O word. A build-time option removes the keeper. With that option set, pull code 2 selects the pull-up instead.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin reads back a control word of 0 and an output bit of 0. Every pin's pad_oe, pad_out, pad_pull, pad_drive and pad_fsel outputs are 0. This means an input pin with no pull, the 2 mA drive code and function 0.
- R2: Pin p's control word is at address 2p and its I/O word is at address 2p+1. The control word packs the function select in bits [FSEL_W-1:0] (FSEL_W = ceil(log2(NUM_FUNCS)), 3 by default), the pull code in bits [5:4], the drive code in bits [10:8] and output-enable in bit 12. Each field reads back as written and appears on the matching pad output. Drive code v stands for (v+1)*2 mA.
- R3: A write changes only the bits whose bus_wmask bit is 1. All other bits of the addressed word keep their value.
- R4: pad_oe follows the output-enable bit. pad_out equals the I/O word's output bit (bit 0) while output-enable is 1, and is 0 while output-enable is 0.
- R5: I/O bit 1 shows pad_in of that pin after exactly two rising clock edges. Writes to bit 1 are ignored.
- R6: With the keeper present, pad_pull gives the pull code unchanged: 0 = none, 1 = pull-down, 2 = keeper, 3 = pull-up.
- R7: With NO_KEEPER set, pad_pull never shows 2. Codes 2 and 3 both give 3 (pull-up). Codes 0 and 1 pass through unchanged.
- R8: A read of an address at or above 2*NUM_PINS returns 0. A write to such an address changes no pin.
- R9: A write to one pin's word leaves the words and pad outputs of every other pin unchanged.
- R10: Control-word bits that belong to no field, and I/O word bits above bit 1, always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address (2*pin + word select) |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wmask | input | DATA_W | Per-bit write mask |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_out | output | NUM_PINS | Level driven toward each pad |
| pad_oe | output | NUM_PINS | Output enable for each pad |
| pad_pull | output | 2*NUM_PINS | Decoded pull code, 2 bits per pin |
| pad_drive | output | 3*NUM_PINS | Drive-strength code, 3 bits per pin |
| pad_fsel | output | FSEL_W*NUM_PINS | Function select, FSEL_W bits per pin |

## Verification
The bench writes a single field under a narrow mask and reads the whole word back. A merge that ignores the mask would wipe the neighbouring fields, and a merge that inverts it would corrupt them. It clears output-enable while the output bit is 1 and checks that pad_out drops, which catches a pad that drives without its enable. It watches the input bit one and then two edges after a pad change, and it writes to that bit. A synchronizer one stage short shows the new level too early, and a writable input bit holds the written value. It runs every pull code on a build with the keeper and on a build without it, and it writes above the mapped range. An incomplete decode there would alias onto a real pin.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        PULL_NONE = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_KEEP = 2'd2,
        PULL_UP   = 2'd3
    } pad_pull_e;

    // control word field positions (the readback layout is part of behaviour)
    localparam int PULL_LSB   = 4;
    localparam int DRV_LSB    = 8;
    localparam int OE_BIT     = 12;
    // I/O word bit positions
    localparam int IO_OUT_BIT = 0;
    localparam int IO_IN_BIT  = 1;

    function automatic pad_pull_e pull_decode(input logic [1:0] code, input bit no_keeper);
        pad_pull_e res;
        unique case (code)
            2'd0:    res = PULL_NONE;
            2'd1:    res = PULL_DOWN;
            2'd2:    res = no_keeper ? PULL_UP : PULL_KEEP;
            default: res = PULL_UP;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
        end else begin
            meta_q   <= din;
            stable_q <= meta_q;
        end
    end

    assign dout = stable_q;

    // cycles since reset, saturating, so the latency check never looks before reset
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
    end

    a_r5_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_bank_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int FSEL_W    = 3,
    parameter bit NO_KEEPER = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              io_we,
    input  logic [DATA_W-1:0] wmask,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pad_in,
    output logic [DATA_W-1:0] ctl_rd,
    output logic [DATA_W-1:0] io_rd,
    output logic              pad_out,
    output logic              pad_oe,
    output logic [1:0]        pad_pull,
    output logic [2:0]        pad_drive,
    output logic [FSEL_W-1:0] pad_fsel
);
    logic [FSEL_W-1:0] fsel_q;
    logic [1:0]        pull_q;
    logic [2:0]        drv_q;
    logic              oe_q;
    logic              out_q;
    logic              in_sync;

    gpio_sync2 u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (in_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsel_q <= '0;
            pull_q <= 2'd0;
            drv_q  <= 3'd0;
            oe_q   <= 1'b0;
            out_q  <= 1'b0;
        end else begin
            if (ctl_we) begin
                fsel_q <= (fsel_q & ~wmask[FSEL_W-1:0]) | (wdata[FSEL_W-1:0] & wmask[FSEL_W-1:0]);
                pull_q <= (pull_q & ~wmask[PULL_LSB +: 2]) | (wdata[PULL_LSB +: 2] & wmask[PULL_LSB +: 2]);
                drv_q  <= (drv_q & ~wmask[DRV_LSB +: 3]) | (wdata[DRV_LSB +: 3] & wmask[DRV_LSB +: 3]);
                if (wmask[OE_BIT]) oe_q <= wdata[OE_BIT];
            end
            if (io_we && wmask[IO_OUT_BIT]) out_q <= wdata[IO_OUT_BIT];
        end
    end

    always_comb begin
        ctl_rd                 = '0;
        ctl_rd[FSEL_W-1:0]     = fsel_q;
        ctl_rd[PULL_LSB +: 2]  = pull_q;
        ctl_rd[DRV_LSB +: 3]   = drv_q;
        ctl_rd[OE_BIT]         = oe_q;
        io_rd                  = '0;
        io_rd[IO_OUT_BIT]      = out_q;
        io_rd[IO_IN_BIT]       = in_sync;
    end

    assign pad_oe    = oe_q;
    assign pad_out   = out_q & oe_q;
    assign pad_pull  = pull_decode(pull_q, NO_KEEPER);
    assign pad_drive = drv_q;
    assign pad_fsel  = fsel_q;

    logic unused_ok;
    assign unused_ok = ^{wdata, wmask};

    a_r3_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(ctl_rd));
    a_r3_oe_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !wmask[OE_BIT]) |=> $stable(pad_oe));
    a_r9_io_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !io_we |=> $stable(io_rd[IO_OUT_BIT]));
    a_r4_disable_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && wmask[OE_BIT] && !wdata[OE_BIT]) |=> !pad_out);

    if (NO_KEEPER) begin : g_nokeep_chk
        a_r7_no_keeper_code: assert property (@(posedge clk) disable iff (!rst_n)
            pad_pull != 2'(PULL_KEEP));
    end

endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux #(
    parameter int NUM_PINS = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 5
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM_PINS*DATA_W-1:0] ctl_flat,
    input  logic [NUM_PINS*DATA_W-1:0] io_flat,
    output logic [DATA_W-1:0]          rdata
);
    logic [ADDR_W-2:0] pin_idx;
    assign pin_idx = addr[ADDR_W-1:1];

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (pin_idx == (ADDR_W-1)'(p)) begin
                rdata = addr[0] ? io_flat[p*DATA_W +: DATA_W] : ctl_flat[p*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
    parameter int NUM_PINS  = 8,
    parameter int NUM_FUNCS = 6,
    parameter bit NO_KEEPER = 1'b0,
    parameter int DATA_W    = 16,
    localparam int FSEL_W   = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1,
    localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int ADDR_W   = PIN_W + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [DATA_W-1:0]          bus_wmask,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_PINS-1:0]        pad_in,
    output logic [NUM_PINS-1:0]        pad_out,
    output logic [NUM_PINS-1:0]        pad_oe,
    output logic [2*NUM_PINS-1:0]      pad_pull,
    output logic [3*NUM_PINS-1:0]      pad_drive,
    output logic [FSEL_W*NUM_PINS-1:0] pad_fsel
);
    logic [NUM_PINS-1:0]        ctl_we_v;
    logic [NUM_PINS-1:0]        io_we_v;
    logic [NUM_PINS*DATA_W-1:0] ctl_flat;
    logic [NUM_PINS*DATA_W-1:0] io_flat;

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            ctl_we_v[p] = bus_we && (bus_addr == ADDR_W'(2*p));
            io_we_v[p]  = bus_we && (bus_addr == ADDR_W'(2*p + 1));
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_pin_slice #(
            .DATA_W   (DATA_W),
            .FSEL_W   (FSEL_W),
            .NO_KEEPER(NO_KEEPER)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_we   (ctl_we_v[p]),
            .io_we    (io_we_v[p]),
            .wmask    (bus_wmask),
            .wdata    (bus_wdata),
            .pad_in   (pad_in[p]),
            .ctl_rd   (ctl_flat[p*DATA_W +: DATA_W]),
            .io_rd    (io_flat[p*DATA_W +: DATA_W]),
            .pad_out  (pad_out[p]),
            .pad_oe   (pad_oe[p]),
            .pad_pull (pad_pull[2*p +: 2]),
            .pad_drive(pad_drive[3*p +: 3]),
            .pad_fsel (pad_fsel[FSEL_W*p +: FSEL_W])
        );
    end

    gpio_bank_rdmux #(
        .NUM_PINS(NUM_PINS),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_rdmux (
        .addr    (bus_addr),
        .ctl_flat(ctl_flat),
        .io_flat (io_flat),
        .rdata   (bus_rdata)
    );

    a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= ADDR_W'(2*NUM_PINS)) |-> (bus_rdata == '0));
    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr >= ADDR_W'(2*NUM_PINS)))
        |=> $stable({pad_oe, pad_pull, pad_drive, pad_fsel}));
    a_r9_one_pin_written: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_we_v, io_we_v}));

endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
    localparam int NP = 8;
    localparam int DW = 16;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wmask = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata, nk_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, nk_out, nk_oe;
    logic [2*NP-1:0] pad_pull, nk_pull;
    logic [3*NP-1:0] pad_drive, nk_drive;
    logic [3*NP-1:0] pad_fsel, nk_fsel;

    always #4 clk = ~clk;

    gpio_bank #(.NUM_PINS(NP), .NUM_FUNCS(6), .NO_KEEPER(1'b0), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wmask(bus_wmask), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
        .pad_drive(pad_drive), .pad_fsel(pad_fsel));

    gpio_bank #(.NUM_PINS(NP), .NUM_FUNCS(6), .NO_KEEPER(1'b1), .DATA_W(DW)) dut_nk_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wmask(bus_wmask), .bus_wdata(bus_wdata), .bus_rdata(nk_rdata),
        .pad_in(pad_in), .pad_out(nk_out), .pad_oe(nk_oe), .pad_pull(nk_pull),
        .pad_drive(nk_drive), .pad_fsel(nk_fsel));

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    logic rd_go = 1'b0;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [DW-1:0] m);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wmask = m; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_addr = a;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        rd_go = 1'b1;
        @(negedge clk);
        rd_go = 1'b0;
    endtask

    // monitor: compares read data against queued expectations
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rd_go && sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'd0, 16'h0000, "R1 ctl pin0");
        rd(5'd7, 16'h0000, "R1 io pin3");
        check("R1 pad_oe", DW'(pad_oe), 16'h0);
        check("R1 pad_out", DW'(pad_out), 16'h0);
        check("R1 pad_pull", pad_pull, 16'h0);
        check("R1 pad_drive", DW'(pad_drive), 16'h0);
        check("R1 pad_fsel", DW'(pad_fsel), 16'h0);

        // R2 / R10 full write to pin2 control
        wr(5'd4, 16'hFFFF, 16'hFFFF);
        rd(5'd4, 16'h1737, "R10 R2 ctl pin2 all ones");
        check("R2 fsel pin2", DW'(pad_fsel[6 +: 3]), 16'd7);
        check("R2 pull pin2", DW'(pad_pull[4 +: 2]), 16'd3);
        check("R2 drive pin2", DW'(pad_drive[6 +: 3]), 16'd7);
        check("R2 oe pin2", DW'(pad_oe[2]), 16'd1);

        // R3 masked field writes
        wr(5'd4, 16'h0000, 16'h0030);
        rd(5'd4, 16'h1707, "R3 clear pull only");
        check("R3 pull pin2", DW'(pad_pull[4 +: 2]), 16'd0);
        wr(5'd4, 16'h0300, 16'h0700);
        rd(5'd4, 16'h1307, "R3 drive only");
        check("R3 drive pin2", DW'(pad_drive[6 +: 3]), 16'd3);

        // R9 neighbours untouched
        rd(5'd2, 16'h0000, "R9 ctl pin1");
        rd(5'd6, 16'h0000, "R9 ctl pin3");
        check("R9 other pads oe", DW'(pad_oe & 8'hFB), 16'h0);

        // R4 output gating
        wr(5'd5, 16'h0001, 16'h0001);
        check("R4 out with oe", DW'(pad_out[2]), 16'd1);
        rd(5'd5, 16'h0001, "R4 io pin2");
        wr(5'd4, 16'h0000, 16'h1000);
        check("R4 oe cleared", DW'(pad_oe[2]), 16'd0);
        check("R4 out gated", DW'(pad_out[2]), 16'd0);
        rd(5'd5, 16'h0001, "R4 out bit kept");
        rd(5'd4, 16'h0307, "R4 R3 ctl after oe clear");

        // R5 synchronizer latency and read-only input bit
        @(negedge clk);
        pad_in[5] = 1'b1;
        bus_addr = 5'd11;
        @(posedge clk); #1;
        check("R5 after one edge", bus_rdata, 16'h0000);
        @(posedge clk); #1;
        check("R5 after two edges", bus_rdata, 16'h0002);
        wr(5'd11, 16'h0000, 16'hFFFF);
        rd(5'd11, 16'h0002, "R5 write ignored high");
        @(negedge clk);
        pad_in[5] = 1'b0;
        repeat (3) @(negedge clk);
        wr(5'd11, 16'h0002, 16'h0002);
        rd(5'd11, 16'h0000, "R5 write ignored low");

        // R6 / R7 pull decoding on both builds
        for (int c = 0; c < 4; c++) begin
            wr(5'd0, DW'(c << 4), 16'h0030);
            check($sformatf("R6 keeper build code %0d", c), DW'(pad_pull[1:0]), DW'(c));
            check($sformatf("R7 no-keeper build code %0d", c), DW'(nk_pull[1:0]), (c >= 2) ? 16'd3 : DW'(c));
        end

        // R8 unmapped addresses
        rd(5'd16, 16'h0000, "R8 read 16");
        rd(5'd31, 16'h0000, "R8 read 31");
        wr(5'd20, 16'hFFFF, 16'hFFFF);
        rd(5'd8, 16'h0000, "R8 ctl pin4 after stray write");
        rd(5'd13, 16'h0000, "R8 io pin6 after stray write");
        check("R8 pad_oe after stray write", DW'(pad_oe), 16'h0);

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) check("scoreboard drained", DW'(sb_q.size()), 16'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule